// File: doc/BRIEF.md
# Serial Shift Engine with Clock Divider

This block is the bit-level core of a clocked serial port. It moves one word at a time between a pair of word queues and the serial pins. As a host it makes the serial clock itself by dividing the core clock. As a target it follows a clock that arrives from outside. It can also watch an optional select pin. The queues and any interrupt logic sit outside the block. Words enter through a valid/ready port and leave through a valid strobe.

The configuration inputs act like the fields of a control register. They set:
- enable and soft reset;
- full-duplex or receive-only operation;
- a 14-bit divisor;
- the clock idle level and the data timing, each encoded inverted relative to the common mode numbering;
- bit order and word length (8 or 16 bits);
- role;
- select enable and select polarity.

A busy output tells the controlling logic when a word is in flight. Software must see busy low before it treats a disable or a soft reset as finished. The configuration must be held stable while busy is high.

Top module: `spi_shift_engine`

## Requirements
- R1: As host, each half period of `sclk_o` lasts exactly `cfg_divisor` core clock cycles, so the serial clock is the core clock divided by twice the divisor. A divisor of 0 behaves as 1.
- R2: When the engine is idle, or in the target role, `sclk_o` sits at its idle level. That level is low when `cfg_clk_idle_low` is 1 and high when it is 0.
- R3: With `cfg_early_data` = 1, the first bit appears on `sdo` before the first clock edge. Input is then sampled on each leading edge and output changes on each trailing edge. With `cfg_early_data` = 0, output changes on each leading edge and input is sampled on each trailing edge. A leading edge is the first edge of each bit.
- R4: `cfg_lsb_first` = 1 sends and receives bit 0 first. `cfg_lsb_first` = 0 sends and receives the top bit of the word first.
- R5: `cfg_wide` = 1 selects 16-bit words (32 clock edges). `cfg_wide` = 0 selects 8-bit words (16 edges), using `tx_data[7:0]`, with `rx_data[15:8]` returned as zero.
- R6: With `cfg_duplex` = 0 (receive-only), the engine shifts words in without using the transmit queue: `tx_ready` stays low. `sdo` is held at 1 while busy, and words follow one another for as long as the engine is enabled.
- R7: As host in full-duplex mode, the engine starts a word only when `tx_valid` is high. When the queue is empty it stops at a word boundary with busy low and the clock idle.
- R8: Clearing `cfg_enable` lets the word in flight finish and deliver its `rx_valid`. Busy then drops and no further word starts.
- R9: Holding `cfg_soft_reset` high makes busy low from the next cycle and discards the word in flight with no `rx_valid`. Once the soft reset is released, the engine resumes normal operation.
- R10: As target (`cfg_target` = 1), the engine shifts on edges of `sclk_i` under the same phase, order and length rules. It returns the received word on `rx_data` and sends its queued word on `sdo`.
- R11: In the target role with `cfg_sel_enable` = 1, clock edges count only while `sel_i` equals `cfg_sel_high`. While the select is inactive, no word is taken from the queue and busy stays low. With `cfg_sel_enable` = 0, the select pin is ignored.
- R12: `busy` is high from the start of a word's shifting until its last clock edge. `rx_valid` pulses for one cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Allows new words to start |
| cfg_soft_reset | input | 1 | Forces the engine idle while high |
| cfg_duplex | input | 1 | 1 = send and receive, 0 = receive only |
| cfg_divisor | input | 14 | Half period of the host clock in core cycles |
| cfg_clk_idle_low | input | 1 | 1 = clock idles low, 0 = idles high |
| cfg_early_data | input | 1 | 1 = data valid before the first edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfg_target | input | 1 | 1 = follow the external clock |
| cfg_sel_enable | input | 1 | Enables the target select input |
| cfg_sel_high | input | 1 | 1 = select active high, 0 = active low |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word taken this cycle when valid |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Received word |
| sclk_o | output | 1 | Serial clock driven as host |
| sclk_i | input | 1 | Serial clock received as target |
| sel_i | input | 1 | Target select pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Word in flight |

## Verification
The hardest situations to reach are the ones that break a word midway.

A soft reset is raised several cycles into a full-duplex host word. At that moment the receive register is half filled and the clock may sit away from its idle level. The bench then checks two things: that no received word surfaces for the aborted transfer, and that the following queued words still come through intact.

Clock edges that arrive at the target while its select is inactive are driven on purpose. The bench then shows, through the untouched transmit queue and a later word of the correct length, that those edges were not counted.

A loopback model answers the host in all sixteen combinations of polarity, timing, order and length.

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DIV_W    = 14,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_soft_reset,
  input  logic              cfg_duplex,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic              cfg_clk_idle_low,
  input  logic              cfg_early_data,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic              cfg_target,
  input  logic              cfg_sel_enable,
  input  logic              cfg_sel_high,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk_o,
  input  logic              sclk_i,
  input  logic              sel_i,
  output logic              sdo,
  input  logic              sdi,
  output logic              busy
);
  localparam int CW = $clog2(2 * WORD_W);
  localparam int IW = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SHIFT} state_t;

  state_t            state;
  logic [DIV_W-1:0]  hc;
  logic [CW-1:0]     ec;
  logic [WORD_W-1:0] word, rx_sr;
  logic              sclk_q, sdo_q, rxv_q;
  logic [2:0]        sck_q;
  logic [1:0]        sel_q;

  wire              cpol      = ~cfg_clk_idle_low;
  wire [CW:0]       nbits     = cfg_wide ? (CW+1)'(WORD_W) : (CW+1)'(NARROW_W);
  wire [CW-1:0]     last_edge = CW'(2 * int'(nbits) - 1);
  wire [IW-1:0]     k         = ec[CW-1:1];
  wire              lead      = ~ec[0];
  wire [DIV_W-1:0]  div_eff   = (cfg_divisor == '0) ? DIV_W'(1) : cfg_divisor;
  wire              sel_ok    = ~cfg_sel_enable | (sel_q[1] == cfg_sel_high);
  wire              host_tick = ~cfg_target && (state == S_SHIFT) && (hc == div_eff - 1'b1);
  wire              ext_edge  = cfg_target && sel_ok && (state != S_IDLE) && (sck_q[1] != sck_q[2]);
  wire              edge_now  = host_tick | ext_edge;
  wire              may_take  = (state == S_IDLE) && cfg_enable && ~cfg_soft_reset && (~cfg_target | sel_ok);
  wire              start     = may_take && (~cfg_duplex | tx_valid);
  wire [WORD_W-1:0] load_word = cfg_duplex ? tx_data : '1;
  wire              samp      = cfg_early_data ? lead : ~lead;
  wire              emit      = cfg_early_data ? (~lead && (int'(k) + 1 < int'(nbits))) : lead;

  function automatic logic [IW-1:0] bit_pos(input int kk);
    return IW'(cfg_lsb_first ? kk : int'(nbits) - 1 - kk);
  endfunction

  assign tx_ready = may_take && cfg_duplex;
  assign busy     = (state == S_SHIFT);
  assign sclk_o   = (busy && ~cfg_target) ? sclk_q : cpol;
  assign sdo      = sdo_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sel_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk_i};
      sel_q <= {sel_q[0], sel_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hc     <= '0;
      ec     <= '0;
      word   <= '0;
      rx_sr  <= '0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b1;
      rxv_q  <= 1'b0;
    end else if (cfg_soft_reset) begin
      state <= S_IDLE;
      hc    <= '0;
      ec    <= '0;
      rxv_q <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          word   <= load_word;
          rx_sr  <= '0;
          ec     <= '0;
          hc     <= '0;
          sclk_q <= cpol;
          sdo_q  <= load_word[bit_pos(0)];
          state  <= cfg_target ? S_ARMED : S_SHIFT;
        end
      end else if (cfg_target && !sel_ok) begin
        state <= S_IDLE;
        ec    <= '0;
      end else if (state == S_ARMED && !cfg_enable) begin
        state <= S_IDLE;
      end else begin
        if (!cfg_target) hc <= host_tick ? '0 : hc + 1'b1;
        if (edge_now) begin
          state <= S_SHIFT;
          if (!cfg_target) sclk_q <= ~sclk_q;
          if (samp) rx_sr[bit_pos(int'(k))] <= sdi;
          if (emit) sdo_q <= word[bit_pos(cfg_early_data ? int'(k) + 1 : int'(k))];
          if (ec == last_edge) begin
            state <= S_IDLE;
            rxv_q <= 1'b1;
            ec    <= '0;
          end else begin
            ec <= ec + 1'b1;
          end
        end
      end
    end
  end

  a_r9_soft_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_soft_reset |=> (!busy && !rx_valid));

  a_r12_strobe_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));

  a_r6_rxonly_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_duplex) |-> sdo);

  a_r7_no_start_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_target && !busy && cfg_duplex && !tx_valid) |=> !busy);

  a_r8_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !busy) |=> !busy);

  a_r11_select_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_target && cfg_sel_enable && (sel_q[1] != cfg_sel_high)) |=> !busy);
endmodule

// File: tb/spi_shift_engine_test.sv
`timescale 1ns/1ps
module spi_shift_engine_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_soft_reset = 0, cfg_duplex = 1;
  logic [13:0] cfg_divisor = 14'd1;
  logic cfg_clk_idle_low = 1, cfg_early_data = 1, cfg_lsb_first = 0, cfg_wide = 0;
  logic cfg_target = 0, cfg_sel_enable = 0, cfg_sel_high = 0;
  logic tx_valid = 0;
  logic [15:0] tx_data = '0;
  logic sclk_i = 0, sel_i = 0, sdi = 0;
  logic tx_ready, rx_valid, sclk_o, sdo, busy;
  logic [15:0] rx_data;

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_soft_reset(cfg_soft_reset),
    .cfg_duplex(cfg_duplex), .cfg_divisor(cfg_divisor), .cfg_clk_idle_low(cfg_clk_idle_low),
    .cfg_early_data(cfg_early_data), .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide),
    .cfg_target(cfg_target), .cfg_sel_enable(cfg_sel_enable), .cfg_sel_high(cfg_sel_high),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk_o(sclk_o), .sclk_i(sclk_i),
    .sel_i(sel_i), .sdo(sdo), .sdi(sdi), .busy(busy));

  logic [15:0] txq[$], sentq[$], rq[$], exprx[$];
  int checks = 0, errors = 0, rx_cnt = 0, seq = 0;
  bit finished = 0, hs = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb();
    return cfg_wide ? 16 : 8;
  endfunction
  function automatic logic [15:0] msk();
    return cfg_wide ? 16'hFFFF : 16'h00FF;
  endfunction
  function automatic int posn(input int k);
    return cfg_lsb_first ? k : nb() - 1 - k;
  endfunction

  always @(negedge clk) begin
    if (hs && txq.size() > 0) sentq.push_back(txq.pop_front());
    tx_valid = (txq.size() > 0);
    tx_data  = tx_valid ? txq[0] : 16'h0;
    #1 hs = tx_valid && tx_ready;
  end

  int e = 0, hp = 0;
  bit in_word = 0, prev_busy = 0, prev_sclk = 0;
  logic [15:0] reply, got, expw;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_soft_reset) begin
        if (in_word) begin
          in_word = 0;
          if (cfg_duplex && sentq.size() > 0) void'(sentq.pop_front());
        end
      end else if (!in_word && busy && !prev_busy && !cfg_target) begin
        in_word = 1; e = 0; hp = 0; got = '0;
        reply = (rq.size() > 0) ? rq.pop_front() : (16'h5A3C ^ 16'(seq * 16'h1111));
        seq++;
        if (cfg_early_data) sdi = reply[posn(0)];
      end else if (in_word) begin
        hp++;
        if (sclk_o != prev_sclk) begin
          chk(hp == ((cfg_divisor == 0) ? 1 : int'(cfg_divisor)), "R1 half period cycles", hp, cfg_divisor);
          hp = 0;
          if (cfg_early_data) begin
            if (e % 2 == 0) got[posn(e / 2)] = sdo;
            else if (e / 2 + 1 < nb()) sdi = reply[posn(e / 2 + 1)];
          end else begin
            if (e % 2 == 0) sdi = reply[posn(e / 2)];
            else got[posn(e / 2)] = sdo;
          end
          e++;
          if (e == 2 * nb()) begin
            in_word = 0;
            expw = cfg_duplex ? ((sentq.size() > 0) ? sentq.pop_front() : 16'h0) : 16'hFFFF;
            chk((got & msk()) == (expw & msk()), "R3 R4 R5 R6 serial word sent by host", got & msk(), expw & msk());
            exprx.push_back(reply & msk());
          end
        end
      end
      if (rx_valid) begin
        rx_cnt++;
        if (exprx.size() > 0) begin
          expw = exprx.pop_front();
          chk(rx_data == expw, "R5 R10 received word", rx_data, expw);
        end else chk(0, "R9 R12 unexpected rx_valid", rx_data, 0);
      end
      if (!cfg_target && !busy) chk(sclk_o == ~cfg_clk_idle_low, "R2 idle clock level", sclk_o, ~cfg_clk_idle_low);
      if (!cfg_duplex) begin
        chk(tx_ready == 0, "R6 tx_ready low in receive-only", tx_ready, 0);
        if (busy) chk(sdo == 1, "R6 sdo ones", sdo, 1);
      end
    end
    prev_busy = busy;
    prev_sclk = sclk_o;
  end

  task automatic wait_rx(input int target, input int maxc, input string tag);
    int c = 0;
    while (rx_cnt < target && c < maxc) begin @(negedge clk); c++; end
    chk(rx_cnt >= target, tag, rx_cnt, target);
  endtask

  task automatic run_host(input bit il, input bit ed, input bit lf, input bit wd, input int dv, input int nw, input int sd);
    int base;
    @(negedge clk);
    cfg_enable = 0; cfg_target = 0; cfg_duplex = 1;
    cfg_clk_idle_low = il; cfg_early_data = ed; cfg_lsb_first = lf; cfg_wide = wd;
    cfg_divisor = 14'(dv);
    base = rx_cnt;
    for (int i = 0; i < nw; i++) begin
      txq.push_back(16'hC3A5 ^ 16'(sd * 16'h0907 + i * 16'h3111));
      rq.push_back(16'h96E1 ^ 16'(sd * 16'h0B03 + i * 16'h1357));
    end
    cfg_enable = 1;
    wait_rx(base + nw, 4000, "R1 R3 host words complete");
    repeat (6) @(negedge clk);
    chk(busy == 0, "R7 stops when queue empty", busy, 0);
    chk(sclk_o == ~il, "R7 clock idle after queue empty", sclk_o, ~il);
    chk(rx_cnt == base + nw, "R7 no extra word", rx_cnt, base + nw);
    cfg_enable = 0;
  endtask

  localparam int H = 6;
  task automatic tgt_xfer(input logic [15:0] mo, input logic [15:0] dw, input string tag);
    int base;
    logic [15:0] g;
    g = '0;
    base = rx_cnt;
    exprx.push_back(mo & msk());
    repeat (6) @(negedge clk);
    if (cfg_early_data) sdi = mo[posn(0)];
    repeat (H) @(negedge clk);
    for (int k = 0; k < nb(); k++) begin
      if (cfg_early_data) begin
        g[posn(k)] = sdo;
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
        sclk_i = ~sclk_i;
        if (k + 1 < nb()) sdi = mo[posn(k + 1)];
        repeat (H) @(negedge clk);
      end else begin
        sclk_i = ~sclk_i;
        sdi = mo[posn(k)];
        repeat (H) @(negedge clk);
        g[posn(k)] = sdo;
        sclk_i = ~sclk_i;
        repeat (H) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(rx_cnt == base + 1, {tag, " target word received"}, rx_cnt, base + 1);
    chk((g & msk()) == (dw & msk()), {tag, " target word sent"}, g & msk(), dw & msk());
  endtask

  task automatic run_target(input bit il, input bit ed, input bit lf, input bit wd, input logic [15:0] mo, input logic [15:0] dw);
    @(negedge clk);
    cfg_enable = 0; cfg_target = 1; cfg_duplex = 1; cfg_sel_enable = 0;
    cfg_clk_idle_low = il; cfg_early_data = ed; cfg_lsb_first = lf; cfg_wide = wd;
    sclk_i = ~il;
    repeat (4) @(negedge clk);
    txq.push_back(dw);
    cfg_enable = 1;
    tgt_xfer(mo, dw, "R10");
    cfg_enable = 0;
  endtask

  initial begin
    int base, rec, c;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R12 busy low in reset", busy, 0);
    chk(rx_valid == 0, "R12 rx_valid low in reset", rx_valid, 0);
    chk(tx_ready == 0, "R7 tx_ready low when disabled", tx_ready, 0);
    chk(sclk_o == 0, "R2 reset clock level", sclk_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int m = 0; m < 16; m++)
      run_host(m[0], m[1], m[2], m[3], (m % 3) + 1, 2, m);
    run_host(1, 1, 0, 0, 0, 1, 21);
    run_host(0, 0, 1, 1, 37, 1, 22);

    @(negedge clk);
    cfg_duplex = 0; cfg_wide = 0; cfg_divisor = 14'd2; cfg_lsb_first = 0;
    txq.push_back(16'h1234);
    base = rx_cnt;
    cfg_enable = 1;
    wait_rx(base + 3, 2000, "R6 receive-only words flow");
    repeat (5) @(negedge clk);
    chk(busy == 1, "R12 busy mid word", busy, 1);
    rec = rx_cnt;
    cfg_enable = 0;
    repeat (200) @(negedge clk);
    chk(rx_cnt == rec + 1, "R8 word in flight finishes", rx_cnt, rec + 1);
    chk(busy == 0, "R8 busy drops after disable", busy, 0);
    chk(txq.size() == 1, "R6 tx queue untouched", txq.size(), 1);
    txq.delete();
    repeat (3) @(negedge clk);
    cfg_duplex = 1;

    cfg_divisor = 14'd3; cfg_wide = 0; cfg_early_data = 1; cfg_clk_idle_low = 1;
    base = rx_cnt;
    for (int i = 0; i < 3; i++) begin
      txq.push_back(16'h00A7 + 16'(i * 16'h0031));
      rq.push_back(16'h004D + 16'(i * 16'h0053));
    end
    cfg_enable = 1;
    c = 0;
    while (!busy && c < 100) begin @(negedge clk); c++; end
    repeat (10) @(negedge clk);
    cfg_soft_reset = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R9 busy cleared by soft reset", busy, 0);
    cfg_soft_reset = 0;
    wait_rx(base + 2, 2000, "R9 resumes after soft reset");
    repeat (60) @(negedge clk);
    chk(rx_cnt == base + 2, "R9 aborted word not delivered", rx_cnt, base + 2);
    cfg_enable = 0;
    rq.delete();
    repeat (3) @(negedge clk);

    run_target(1, 1, 0, 0, 16'h00B4, 16'h0069);
    run_target(0, 0, 1, 1, 16'h8E17, 16'h3AC5);
    run_target(1, 0, 0, 1, 16'h4D2B, 16'hF019);
    run_target(0, 1, 1, 0, 16'h0037, 16'h00C8);

    @(negedge clk);
    cfg_target = 1; cfg_duplex = 1; cfg_sel_enable = 1; cfg_sel_high = 1; sel_i = 0;
    cfg_early_data = 1; cfg_wide = 0; cfg_lsb_first = 0; cfg_clk_idle_low = 1;
    sclk_i = 0;
    repeat (4) @(negedge clk);
    txq.push_back(16'h005E);
    cfg_enable = 1;
    for (int t = 0; t < 6; t++) begin
      sclk_i = ~sclk_i;
      repeat (H) @(negedge clk);
      chk(busy == 0, "R11 inactive select ignored", busy, 0);
    end
    chk(txq.size() == 1, "R11 no word taken while deselected", txq.size(), 1);
    sel_i = 1;
    tgt_xfer(16'h00A3, 16'h005E, "R11 active high");
    sel_i = 0; cfg_enable = 0;
    repeat (4) @(negedge clk);
    cfg_sel_high = 0;
    repeat (4) @(negedge clk);
    txq.push_back(16'h0071);
    cfg_enable = 1;
    tgt_xfer(16'h001C, 16'h0071, "R11 active low");
    cfg_enable = 0; sel_i = 1;
    repeat (10) @(negedge clk);
    sentq.delete();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule